// File: doc/BRIEF.md
# Reset and Sleep Mode Controller

This block gathers every reset request of a network controller into one internal reset and runs the controller's low-power states. Three supply-monitor requests and the chip reset pin act at once, without waiting for a clock edge. An EEPROM checksum failure, a Plug and Play reset command and a software reset bit are sampled on the clock. On release, the internal reset goes through a two-flop synchronizer and then stays asserted for a programmable minimum number of cycles. A one-hot cause word records which of nine causes reset the core last. The host clears a bit of it by writing a 1 to that bit.

A two-bit sleep request, driven from a configuration register, selects among running, standby and suspend. Standby turns off every domain except the receiver. Line activity seen by the receiver wakes the block again, and this wake-up resets the core but not the receiver. Suspend turns off every domain and ignores line activity. The host leaves suspend by moving the request back to running, and this exit causes a full reset. Leaving a sleep state, whichever way, is itself a reset cause. The transmit and receive enables start cleared after every reset and are set only by explicit configuration pulses.

Top module: `rstsleep_ctrl`

## Requirements
- R1: The cause word is one-hot or zero, with these bit positions: bits 0 to 2 for the supply monitors, bit 3 for the EEPROM checksum failure, bit 4 for the Plug and Play command, bit 5 for the software reset, bit 6 for the exit from suspend, bit 7 for the host exit from standby, bit 8 for the wake-up from standby. Reset through `rst_n` loads 0x001.
- R2: When several requests are sampled on the same edge, the lowest-numbered bit is recorded. A supply-monitor request therefore always wins over the others.
- R3: Writing 1 to a bit of `cause_clr` clears that cause bit, and writing 1 to any other bit leaves the word unchanged. A new request sampled on the same edge is recorded and the clear is ignored.
- R4: `int_rst` goes high at once while `rst_n` is low or a supply request is high. After both are released it stays high for 2 synchronizer cycles plus HOLD_CYC cycles (6 samples with the default HOLD_CYC = 4). A sampled synchronous request keeps it high for exactly HOLD_CYC cycles, counted from the edge that samples the request.
- R5: `tx_en` and `rx_en` are 0 after any reset and stay 0 while `int_rst` is high. They become 1 only through a `cfg_tx_set` or `cfg_rx_set` pulse, and a pulse is ignored while `int_rst` is high.
- R6: In suspend (`sleep_mode` = 2'b10), `core_en` and `rx_pwr_en` are both 0. Line activity has no effect there: the enables and the cause word stay unchanged.
- R7: In standby (`sleep_mode` = 2'b01), `core_en` is 0 and `rx_pwr_en` is 1.
- R8: Line activity during standby returns the block to running. This sets `core_en` and raises `int_rst` while keeping `rx_rst` at 0, and records cause bit 8.
- R9: Setting `sleep_mode` to running (2'b00 or 2'b11) in standby records cause bit 7 and resets the core only. Leaving suspend records cause bit 6 and raises both `int_rst` and `rx_rst`.
- R10: After any exit from a sleep state, the block does not enter a sleep state again until `sleep_mode` has shown running for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| supply_req | input | 3 | Supply-monitor reset requests, active high, asynchronous assert |
| eeprom_bad | input | 1 | EEPROM checksum failure flag |
| pnp_reset | input | 1 | Plug and Play reset command |
| sw_reset | input | 1 | Software reset bit |
| sleep_mode | input | 2 | Sleep request: 00/11 running, 01 standby, 10 suspend |
| line_act | input | 1 | Receive line activity detected |
| cause_clr | input | 9 | Write-one-to-clear strobe for the cause word |
| cfg_tx_set | input | 1 | Configuration pulse that enables transmit |
| cfg_rx_set | input | 1 | Configuration pulse that enables receive |
| int_rst | output | 1 | Internal core reset, active high |
| rx_rst | output | 1 | Receiver domain reset, active high |
| core_en | output | 1 | Enable for every domain except the receiver |
| rx_pwr_en | output | 1 | Receiver domain enable |
| tx_en | output | 1 | Packet transmit enable |
| rx_en | output | 1 | Packet receive enable |
| cause | output | 9 | One-hot cause of the last reset |

## Verification
On every clock the assertions check these properties: the cause word stays one-hot, a supply request wins the recorded cause, cleared bits drop, the enables stay low under reset, suspend holds against line activity, and a standby wake-up spares the receiver. Only the bench scenarios can show the exact release timing. This covers the two-flop release after asynchronous reset and the HOLD_CYC length after a sampled request. The same holds for the re-arm rule after a sleep exit and the distinction between the two standby exits. These need directed sequences over many cycles, with expected values counted from the stimulus edge.

// File: rtl/rstsleep_pkg.sv
package rstsleep_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_STBY = 2'd1,
    ST_SUSP = 2'd2
  } pwr_state_e;

  localparam logic [1:0] MODE_STBY = 2'b01;
  localparam logic [1:0] MODE_SUSP = 2'b10;

  // offsets of the non-supply causes, added to the supply count
  localparam int OFS_EEPROM = 0;
  localparam int OFS_PNP    = 1;
  localparam int OFS_SW     = 2;
  localparam int OFS_SUSP   = 3;
  localparam int OFS_STBY   = 4;
  localparam int OFS_WAKE   = 5;
  localparam int N_OTHER    = 6;

  function automatic logic mode_is_run(input logic [1:0] m);
    return (m != MODE_STBY) && (m != MODE_SUSP);
  endfunction

endpackage

// File: rtl/rstsleep_stretch.sv
module rstsleep_stretch #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic restart,
  input  logic core_only_req,
  output logic rst_o,
  output logic rx_rst_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] CNT_DONE = CW'(HOLD_CYC);

  logic          sync1_q, sync2_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          core_only_q, core_only_d;

  // two-flop release of the asynchronous reset
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    cnt_d       = cnt_q;
    core_only_d = core_only_q;
    if (restart) begin
      cnt_d       = '0;
      core_only_d = core_only_req;
    end else if (sync2_q && (cnt_q != CNT_DONE)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q       <= '0;
      core_only_q <= 1'b0;
    end else begin
      cnt_q       <= cnt_d;
      core_only_q <= core_only_d;
    end
  end

  assign rst_o    = (cnt_q != CNT_DONE);
  assign rx_rst_o = rst_o && !core_only_q;

  assert_restart_holds_R4: assert property (@(posedge clk) disable iff (!arst_n)
    restart |=> rst_o);
  assert_sync_holds_R4: assert property (@(posedge clk) disable iff (!arst_n)
    !sync2_q |-> rst_o);

endmodule

// File: rtl/rstsleep_cause.sv
module rstsleep_cause #(
  parameter int N_SUP = 3,
  parameter int NC    = N_SUP + 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NC-1:0] req,
  input  logic [NC-1:0] clr,
  output logic [NC-1:0] cause
);
  logic [NC-1:0] pick;
  logic [NC-1:0] cause_q, cause_d;

  // lowest index wins: supply causes sit at the bottom
  always_comb begin
    pick = '0;
    for (int i = NC - 1; i >= 0; i--) begin
      if (req[i]) pick = NC'(1) << i;
    end
  end

  always_comb begin
    if (|req) cause_d = pick;
    else      cause_d = cause_q & ~clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= NC'(1);
    else        cause_q <= cause_d;
  end

  assign cause = cause_q;

  assert_cause_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cause_q));
  assert_supply_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|req[N_SUP-1:0]) |=> (|cause_q[N_SUP-1:0]));
  assert_clear_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|req) && (|(clr & cause_q))) |=> ((cause_q & $past(clr)) == '0));

endmodule

// File: rtl/rstsleep_fsm.sv
module rstsleep_fsm
  import rstsleep_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic [1:0] mode,
  input  logic       line_act,
  output logic       core_en,
  output logic       rxd_en,
  output logic       ev_susp_exit,
  output logic       ev_stby_host,
  output logic       ev_stby_wake
);
  pwr_state_e state_q, state_d;
  logic       armed_q, armed_d;
  logic       run_req;

  assign run_req = mode_is_run(mode);

  always_comb begin
    state_d      = state_q;
    armed_d      = armed_q;
    ev_susp_exit = 1'b0;
    ev_stby_host = 1'b0;
    ev_stby_wake = 1'b0;
    if (run_req) armed_d = 1'b1;
    unique case (state_q)
      ST_RUN: begin
        if (armed_q && mode == MODE_STBY)      state_d = ST_STBY;
        else if (armed_q && mode == MODE_SUSP) state_d = ST_SUSP;
      end
      ST_STBY: begin
        if (line_act) begin
          state_d      = ST_RUN;
          ev_stby_wake = 1'b1;
          armed_d      = 1'b0;
        end else if (run_req) begin
          state_d      = ST_RUN;
          ev_stby_host = 1'b1;
          armed_d      = 1'b0;
        end else if (mode == MODE_SUSP) begin
          state_d = ST_SUSP;
        end
      end
      ST_SUSP: begin
        if (mode != MODE_SUSP) begin
          state_d      = ST_RUN;
          ev_susp_exit = 1'b1;
          armed_d      = 1'b0;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_RUN;
      armed_q <= 1'b1;
    end else begin
      state_q <= state_d;
      armed_q <= armed_d;
    end
  end

  assign core_en = (state_q == ST_RUN);
  assign rxd_en  = (state_q != ST_SUSP);

  assert_one_exit_R9: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0({ev_susp_exit, ev_stby_host, ev_stby_wake}));
  assert_rearm_R10: assert property (@(posedge clk) disable iff (!arst_n)
    (ev_susp_exit || ev_stby_host || ev_stby_wake) |=> (state_q == ST_RUN));

endmodule

// File: rtl/rstsleep_ctrl.sv
module rstsleep_ctrl
  import rstsleep_pkg::*;
#(
  parameter int HOLD_CYC = 4,
  parameter int N_SUP    = 3,
  localparam int NC      = N_SUP + N_OTHER
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SUP-1:0] supply_req,
  input  logic             eeprom_bad,
  input  logic             pnp_reset,
  input  logic             sw_reset,
  input  logic [1:0]       sleep_mode,
  input  logic             line_act,
  input  logic [NC-1:0]    cause_clr,
  input  logic             cfg_tx_set,
  input  logic             cfg_rx_set,
  output logic             int_rst,
  output logic             rx_rst,
  output logic             core_en,
  output logic             rx_pwr_en,
  output logic             tx_en,
  output logic             rx_en,
  output logic [NC-1:0]    cause
);
  logic          arst_n;
  logic          ev_susp, ev_host, ev_wake;
  logic          full_req, restart, core_only;
  logic [NC-1:0] req_vec;
  logic          tx_q, tx_d, rx_q, rx_d;

  // supply requests join the chip reset pin asynchronously
  assign arst_n = rst_n && !(|supply_req);

  rstsleep_fsm u_fsm (
    .clk          (clk),
    .arst_n       (arst_n),
    .mode         (sleep_mode),
    .line_act     (line_act),
    .core_en      (core_en),
    .rxd_en       (rx_pwr_en),
    .ev_susp_exit (ev_susp),
    .ev_stby_host (ev_host),
    .ev_stby_wake (ev_wake)
  );

  assign full_req  = eeprom_bad || pnp_reset || sw_reset || ev_susp;
  assign restart   = full_req || ev_host || ev_wake;
  assign core_only = !full_req;

  rstsleep_stretch #(.HOLD_CYC(HOLD_CYC)) u_stretch (
    .clk           (clk),
    .arst_n        (arst_n),
    .restart       (restart),
    .core_only_req (core_only),
    .rst_o         (int_rst),
    .rx_rst_o      (rx_rst)
  );

  always_comb begin
    req_vec                     = '0;
    req_vec[N_SUP-1:0]          = supply_req;
    req_vec[N_SUP + OFS_EEPROM] = eeprom_bad;
    req_vec[N_SUP + OFS_PNP]    = pnp_reset;
    req_vec[N_SUP + OFS_SW]     = sw_reset;
    req_vec[N_SUP + OFS_SUSP]   = ev_susp;
    req_vec[N_SUP + OFS_STBY]   = ev_host;
    req_vec[N_SUP + OFS_WAKE]   = ev_wake;
  end

  rstsleep_cause #(.N_SUP(N_SUP), .NC(NC)) u_cause (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_vec),
    .clr   (cause_clr),
    .cause (cause)
  );

  // packet enables: cleared by any reset, set only by configuration
  always_comb begin
    tx_d = tx_q;
    rx_d = rx_q;
    if (int_rst || restart) begin
      tx_d = 1'b0;
      rx_d = 1'b0;
    end else begin
      if (cfg_tx_set) tx_d = 1'b1;
      if (cfg_rx_set) rx_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      tx_q <= 1'b0;
      rx_q <= 1'b0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign tx_en = tx_q;
  assign rx_en = rx_q;

  assert_enables_low_R5: assert property (@(posedge clk) disable iff (!arst_n)
    int_rst |-> (!tx_en && !rx_en));
  assert_suspend_deaf_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (!rx_pwr_en && line_act && sleep_mode == MODE_SUSP) |=> (!rx_pwr_en && !core_en));
  assert_standby_stays_R7: assert property (@(posedge clk) disable iff (!arst_n)
    (!core_en && rx_pwr_en && !line_act && sleep_mode == MODE_STBY) |=> (!core_en && rx_pwr_en));
  assert_wake_spares_rx_R8: assert property (@(posedge clk) disable iff (!arst_n)
    (!core_en && rx_pwr_en && line_act && !eeprom_bad && !pnp_reset && !sw_reset)
      |=> (core_en && int_rst && !rx_rst && cause[N_SUP + OFS_WAKE]));

endmodule

// File: tb/rstsleep_ctrl_test.sv
module rstsleep_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] supply_req;
  logic       eeprom_bad, pnp_reset, sw_reset;
  logic [1:0] sleep_mode;
  logic       line_act;
  logic [8:0] cause_clr;
  logic       cfg_tx_set, cfg_rx_set;
  logic       int_rst, rx_rst, core_en, rx_pwr_en, tx_en, rx_en;
  logic [8:0] cause;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  rstsleep_ctrl uut (
    .clk(clk), .rst_n(rst_n), .supply_req(supply_req), .eeprom_bad(eeprom_bad),
    .pnp_reset(pnp_reset), .sw_reset(sw_reset), .sleep_mode(sleep_mode),
    .line_act(line_act), .cause_clr(cause_clr), .cfg_tx_set(cfg_tx_set),
    .cfg_rx_set(cfg_rx_set), .int_rst(int_rst), .rx_rst(rx_rst), .core_en(core_en),
    .rx_pwr_en(rx_pwr_en), .tx_en(tx_en), .rx_en(rx_en), .cause(cause)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // called at the first negedge after the stimulus edge
  task automatic count_rst(output int n);
    n = 0;
    while (int_rst && n < 50) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic settle();
    int n;
    count_rst(n);
    repeat (2) @(negedge clk);
  endtask

  task automatic configure();
    cfg_tx_set = 1; cfg_rx_set = 1;
    @(negedge clk);
    cfg_tx_set = 0; cfg_rx_set = 0;
  endtask

  task automatic t_power_on();
    int n;
    rst_n = 0;
    #1;
    chk("R4", "int_rst in reset", int_rst, 1);
    chk("R1", "cause in reset", cause, 9'h001);
    chk("R5", "tx_en in reset", tx_en, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    count_rst(n);
    chk("R4", "release samples after rst_n", n, 5);
    chk("R1", "cause after power-on", cause, 9'h001);
    chk("R5", "rx_en before configuration", rx_en, 0);
  endtask

  task automatic t_supply_priority();
    int n;
    configure();
    chk("R5", "tx_en after configuration", tx_en, 1);
    supply_req = 3'b010; sw_reset = 1;
    #1;
    chk("R4", "int_rst on supply request", int_rst, 1);
    chk("R5", "tx_en cleared by supply reset", tx_en, 0);
    @(negedge clk);
    chk("R2", "supply wins over software", cause, 9'h002);
    supply_req = 3'b000; sw_reset = 0;
    @(negedge clk);
    count_rst(n);
    chk("R4", "release samples after supply", n, 5);
  endtask

  task automatic t_sync_sources();
    int n;
    configure();
    cfg_tx_set = 1;
    sw_reset   = 1;
    @(negedge clk);
    sw_reset = 0; cfg_tx_set = 0;
    chk("R1", "software cause", cause, 9'h020);
    chk("R5", "tx_en cleared by software reset", tx_en, 0);
    chk("R5", "rx_en cleared by software reset", rx_en, 0);
    cfg_rx_set = 1;
    @(negedge clk);
    cfg_rx_set = 0;
    chk("R5", "set pulse ignored during reset", rx_en, 0);
    count_rst(n);
    chk("R4", "hold after sync request", n, 3);
    eeprom_bad = 1; pnp_reset = 1;
    @(negedge clk);
    eeprom_bad = 0; pnp_reset = 0;
    chk("R2", "eeprom wins over pnp", cause, 9'h008);
    count_rst(n);
    chk("R4", "hold after eeprom", n, 4);
    pnp_reset = 1;
    @(negedge clk);
    pnp_reset = 0;
    chk("R1", "pnp cause", cause, 9'h010);
    settle();
  endtask

  task automatic t_clear();
    cause_clr = 9'h001;
    @(negedge clk);
    cause_clr = 9'h000;
    chk("R3", "clear of other bit ignored", cause, 9'h010);
    cause_clr = 9'h010; sw_reset = 1;
    @(negedge clk);
    cause_clr = 9'h000; sw_reset = 0;
    chk("R3", "new request beats clear", cause, 9'h020);
    settle();
    cause_clr = 9'h020;
    @(negedge clk);
    cause_clr = 9'h000;
    chk("R3", "write one clears", cause, 9'h000);
  endtask

  task automatic t_standby();
    int n;
    sleep_mode = 2'b01;
    @(negedge clk);
    chk("R7", "standby core_en", core_en, 0);
    chk("R7", "standby rx_pwr_en", rx_pwr_en, 1);
    repeat (3) @(negedge clk);
    chk("R7", "standby held", core_en, 0);
    line_act = 1;
    @(negedge clk);
    line_act = 0;
    chk("R8", "wake core_en", core_en, 1);
    chk("R8", "wake int_rst", int_rst, 1);
    chk("R8", "wake spares receiver", rx_rst, 0);
    chk("R8", "wake cause", cause, 9'h100);
    count_rst(n);
    chk("R8", "wake reset length", n, 4);
    repeat (3) @(negedge clk);
    chk("R10", "no re-entry without run", core_en, 1);
    sleep_mode = 2'b11;
    @(negedge clk);
    sleep_mode = 2'b01;
    @(negedge clk);
    chk("R10", "re-entry after run code 11", core_en, 0);
    sleep_mode = 2'b00;
    @(negedge clk);
    chk("R9", "host exit cause", cause, 9'h080);
    chk("R9", "host exit core reset", int_rst, 1);
    chk("R9", "host exit spares receiver", rx_rst, 0);
    settle();
  endtask

  task automatic t_suspend();
    sleep_mode = 2'b10;
    @(negedge clk);
    chk("R6", "suspend core_en", core_en, 0);
    chk("R6", "suspend rx_pwr_en", rx_pwr_en, 0);
    line_act = 1;
    repeat (2) @(negedge clk);
    line_act = 0;
    chk("R6", "line activity ignored rx_pwr_en", rx_pwr_en, 0);
    chk("R6", "line activity ignored core_en", core_en, 0);
    chk("R6", "line activity ignored cause", cause, 9'h080);
    sleep_mode = 2'b00;
    @(negedge clk);
    chk("R9", "suspend exit cause", cause, 9'h040);
    chk("R9", "suspend exit int_rst", int_rst, 1);
    chk("R9", "suspend exit rx_rst", rx_rst, 1);
    chk("R9", "suspend exit core_en", core_en, 1);
    settle();
    chk("R5", "tx_en after suspend exit", tx_en, 0);
  endtask

  initial begin
    rst_n = 0; supply_req = 0; eeprom_bad = 0; pnp_reset = 0; sw_reset = 0;
    sleep_mode = 2'b00; line_act = 0; cause_clr = 0; cfg_tx_set = 0; cfg_rx_set = 0;
    @(negedge clk);
    t_power_on();
    t_supply_priority();
    t_sync_sources();
    t_clear();
    t_standby();
    t_suspend();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule